// File: doc/BRIEF.md
# Serial Bootloader Frame Interface

This block is the device-side front end of a bootloader reached over a test-access-style serial port. It runs on the shift clock. Each frame is 10 bits wide and moves in both directions at once. The host shifts a frame in on `tdi` while the block shifts its response frame out on `tdo`. In both directions the upper eight bits of a frame hold a data byte and the lowest two bits hold a status field. Bit 0 of a frame is the first bit on the wire.

The host first sends a command byte, then the data-in bytes the command needs, then one NOP byte of 00h. The block looks the command up in a built-in length table and collects the data-in bytes. After the NOP it raises a request to a command executor and holds it until the executor reports completion.

While the request is outstanding, every frame the host sends returns a busy status, so the host can poll with zero frames. Once completion has been seen, the block returns each data-out byte marked done, followed by the return byte 3Eh. It then waits for the next command.

Top module: `sbl_frame_if`

## Requirements
- R1: A frame is 10 bits. Bits [9:2] hold the byte and bits [1:0] hold the status. Bit 0 is shifted first. The block samples `tdi` on the rising edge of `clk` and changes `tdo` on the falling edge. Response bit k is therefore valid at the rising edge that samples host bit k.
- R2: The status bits of frames from the host are ignored. A command behaves the same whether they carry 00 or any other value.
- R3: The command table is as follows. 01h takes 0 data-in and 2 data-out bytes. 22h takes 4 in and 0 out. 33h takes 1 in and 0 out. 44h takes 4 in and 2 out. 55h takes 2 in and 4 out. All other codes are unknown.
- R4: Response frames returned during the command, data-in and NOP frames are 000h, which is byte 00h with status 00.
- R5: At the end of the NOP frame of a known command, `exec_req` rises. `exec_cmd` then holds the command byte. `exec_din` holds data-in byte i in bits [8i+7:8i], in arrival order, with unused bytes at zero. `exec_req` stays high until the cycle after `exec_done` is seen.
- R6: For a known command, the frame after the NOP frame, and each later frame until completion has been seen, returns byte 00h with status 10. There is always at least one such frame.
- R7: The first response frame with status 11 carries data-out byte 0. Later frames carry the next data-out bytes in order, each with status 11. Data-out byte i is taken from `exec_dout` bits [8i+7:8i] in the cycle `exec_done` is high.
- R8: After the last data-out byte, or directly when there are none, one frame returns byte 3Eh with status 11. After that frame the block waits for a new command byte.
- R9: For an unknown command, the command byte is followed directly by the NOP frame. The frame after the NOP returns 3Eh with status 11, and no request is made.
- R10: A synchronous active-high reset returns the block to waiting for a command byte. It drops `exec_req`, clears the collected data-in bytes, and makes the next response frame 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial response to the host, updated on the falling edge |
| exec_req | output | 1 | Request to the executor, held until completion |
| exec_cmd | output | 8 | Command byte of the pending request |
| exec_din | output | 32 | Collected data-in bytes, byte 0 in the low bits |
| exec_done | input | 1 | One-cycle completion pulse from the executor |
| exec_dout | input | 32 | Data-out bytes, valid while `exec_done` is high |

## Verification
The assertions take for granted that the executor pulses `exec_done` only while `exec_req` is high. They also assume the host shifts frames back to back, with bit 0 sampled at the first rising edge after reset is released. The bench's stub executor answers only after it has seen the request at a falling edge, and it drops `exec_done` after one cycle. The host tasks change `tdi` only just after falling edges. Each reset is released just after a rising edge, so frame alignment is never ambiguous.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  localparam int FRAME_W  = 10;
  localparam int STAT_W   = 2;
  localparam int BYTE_W   = FRAME_W - STAT_W;
  localparam int MAX_DIN  = 4;
  localparam int MAX_DOUT = 4;
  localparam int CNT_W    = $clog2(((MAX_DIN > MAX_DOUT) ? MAX_DIN : MAX_DOUT) + 1);

  localparam logic [BYTE_W-1:0] RET_BYTE = 8'h3E;

  localparam logic [STAT_W-1:0] ST_QUIET = 2'b00;
  localparam logic [STAT_W-1:0] ST_BUSY  = 2'b10;
  localparam logic [STAT_W-1:0] ST_DONE  = 2'b11;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_DIN,
    PH_NOP,
    PH_WAIT,
    PH_OUT,
    PH_RET
  } phase_t;

  typedef struct packed {
    logic             known;
    logic [CNT_W-1:0] n_in;
    logic [CNT_W-1:0] n_out;
  } cmd_info_t;

  // Byte counts per command code; any code not listed is unknown.
  function automatic cmd_info_t cmd_lookup(input logic [BYTE_W-1:0] code);
    cmd_info_t r;
    r = '0;
    case (code)
      8'h01: begin r.known = 1'b1; r.n_in = CNT_W'(0); r.n_out = CNT_W'(2); end
      8'h22: begin r.known = 1'b1; r.n_in = CNT_W'(4); r.n_out = CNT_W'(0); end
      8'h33: begin r.known = 1'b1; r.n_in = CNT_W'(1); r.n_out = CNT_W'(0); end
      8'h44: begin r.known = 1'b1; r.n_in = CNT_W'(4); r.n_out = CNT_W'(2); end
      8'h55: begin r.known = 1'b1; r.n_in = CNT_W'(2); r.n_out = CNT_W'(4); end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sbl_frame_shifter.sv
module sbl_frame_shifter
  import sbl_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tdi,
  input  logic [FW-1:0] tx_word,
  output logic          tdo,
  output logic          frame_done,
  output logic [BW-1:0] rx_byte
);

  localparam int BIT_W = $clog2(FW);

  logic [BIT_W-1:0] bit_cnt;
  logic [BW-2:0]    sr;

  // Only the last BW-1 bits are kept, so the two status bits fall out.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sr      <= '0;
    end else begin
      sr      <= {tdi, sr[BW-2:1]};
      bit_cnt <= (bit_cnt == BIT_W'(FW - 1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign frame_done = (bit_cnt == BIT_W'(FW - 1));
  assign rx_byte    = {tdi, sr};

  always_ff @(negedge clk) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= tx_word[bit_cnt];
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (bit_cnt == '0)); // R1
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(bit_cnt) < FW)); // R1

endmodule

// File: rtl/sbl_din_buf.sv
module sbl_din_buf
  import sbl_pkg::*;
#(
  parameter int DEPTH = MAX_DIN,
  parameter int BW    = BYTE_W,
  parameter int IDX_W = CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [BW-1:0]       wr_byte,
  output logic [DEPTH*BW-1:0] bytes_flat
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [BW-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst || clr)                         slot <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))  slot <= wr_byte;
    end
    assign bytes_flat[i*BW +: BW] = slot;
  end

endmodule

// File: rtl/sbl_cmd_seq.sv
module sbl_cmd_seq
  import sbl_pkg::*;
#(
  parameter int FW   = FRAME_W,
  parameter int BW   = BYTE_W,
  parameter int NOUT = MAX_DOUT,
  parameter int CW   = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_done,
  input  logic [BW-1:0]  rx_byte,
  output logic [FW-1:0]  tx_word,
  output logic           din_clr,
  output logic           din_wr,
  output logic [CW-1:0]  din_idx,
  output logic           exec_req,
  output logic [BW-1:0]  exec_cmd,
  input  logic           exec_done,
  input  logic [NOUT*BW-1:0] exec_dout
);

  phase_t          phase;
  cmd_info_t       info;
  cmd_info_t       cur_info;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   cmd_r;
  logic [NOUT*BW-1:0] dout_r;
  logic            done_seen;
  logic            req_r;
  logic [FW-1:0]   tx_r;

  assign cur_info = cmd_lookup(rx_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      info      <= '0;
      cnt       <= '0;
      cmd_r     <= '0;
      dout_r    <= '0;
      done_seen <= 1'b0;
      req_r     <= 1'b0;
      tx_r      <= '0;
    end else begin
      if (exec_done && req_r) begin
        req_r     <= 1'b0;
        done_seen <= 1'b1;
        dout_r    <= exec_dout;
      end
      if (frame_done) begin
        case (phase)
          PH_CMD: begin
            cmd_r     <= rx_byte;
            info      <= cur_info;
            cnt       <= '0;
            done_seen <= 1'b0;
            tx_r      <= {8'h00, ST_QUIET};
            phase     <= (cur_info.known && cur_info.n_in != '0) ? PH_DIN : PH_NOP;
          end
          PH_DIN: begin
            cnt  <= cnt + 1'b1;
            tx_r <= {8'h00, ST_QUIET};
            if (cnt == info.n_in - CW'(1)) phase <= PH_NOP;
          end
          PH_NOP: begin
            cnt <= '0;
            if (info.known) begin
              req_r <= 1'b1;
              tx_r  <= {8'h00, ST_BUSY};
              phase <= PH_WAIT;
            end else begin
              tx_r  <= {RET_BYTE, ST_DONE};
              phase <= PH_RET;
            end
          end
          PH_WAIT: begin
            if (!done_seen) begin
              tx_r <= {8'h00, ST_BUSY};
            end else if (info.n_out == '0) begin
              tx_r  <= {RET_BYTE, ST_DONE};
              phase <= PH_RET;
            end else begin
              tx_r  <= {dout_r[BW-1:0], ST_DONE};
              cnt   <= CW'(1);
              phase <= PH_OUT;
            end
          end
          PH_OUT: begin
            if (cnt == info.n_out) begin
              tx_r  <= {RET_BYTE, ST_DONE};
              phase <= PH_RET;
            end else begin
              tx_r <= {dout_r[int'(cnt)*BW +: BW], ST_DONE};
              cnt  <= cnt + 1'b1;
            end
          end
          default: begin
            tx_r  <= {8'h00, ST_QUIET};
            phase <= PH_CMD;
          end
        endcase
      end
    end
  end

  assign tx_word  = tx_r;
  assign exec_req = req_r;
  assign exec_cmd = cmd_r;
  assign din_clr  = frame_done && (phase == PH_CMD);
  assign din_wr   = frame_done && (phase == PH_DIN);
  assign din_idx  = cnt;

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    exec_done |-> req_r); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_r && !exec_done) |=> req_r); // R5
  AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD || phase == PH_DIN || phase == PH_NOP) |-> (tx_word[1:0] == ST_QUIET)); // R4
  AST_BUSY_UNTIL_SEEN: assert property (@(posedge clk) disable iff (rst)
    (frame_done && phase == PH_WAIT && !done_seen) |=> (tx_word == {8'h00, ST_BUSY})); // R6
  AST_RET_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && phase == PH_RET) |=> (phase == PH_CMD && tx_word == '0)); // R8
  AST_UNKNOWN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (frame_done && phase == PH_NOP && !info.known) |=> (!req_r && tx_word == {RET_BYTE, ST_DONE})); // R9

endmodule

// File: rtl/sbl_frame_if.sv
module sbl_frame_if
  import sbl_pkg::*;
#(
  parameter int FW   = FRAME_W,
  parameter int BW   = BYTE_W,
  parameter int NIN  = MAX_DIN,
  parameter int NOUT = MAX_DOUT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  output logic              tdo,
  output logic              exec_req,
  output logic [BW-1:0]     exec_cmd,
  output logic [NIN*BW-1:0] exec_din,
  input  logic              exec_done,
  input  logic [NOUT*BW-1:0] exec_dout
);

  logic             frame_done;
  logic [BW-1:0]    rx_byte;
  logic [FW-1:0]    tx_word;
  logic             din_clr;
  logic             din_wr;
  logic [CNT_W-1:0] din_idx;

  sbl_frame_shifter #(.FW(FW), .BW(BW)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tdi        (tdi),
    .tx_word    (tx_word),
    .tdo        (tdo),
    .frame_done (frame_done),
    .rx_byte    (rx_byte)
  );

  sbl_cmd_seq #(.FW(FW), .BW(BW), .NOUT(NOUT), .CW(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .tx_word    (tx_word),
    .din_clr    (din_clr),
    .din_wr     (din_wr),
    .din_idx    (din_idx),
    .exec_req   (exec_req),
    .exec_cmd   (exec_cmd),
    .exec_done  (exec_done),
    .exec_dout  (exec_dout)
  );

  sbl_din_buf #(.DEPTH(NIN), .BW(BW), .IDX_W(CNT_W)) u_din (
    .clk        (clk),
    .rst        (rst),
    .clr        (din_clr),
    .wr_en      (din_wr),
    .wr_idx     (din_idx),
    .wr_byte    (rx_byte),
    .bytes_flat (exec_din)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !exec_req); // R10

endmodule

// File: tb/sbl_frame_if_tb_top.sv
module sbl_frame_if_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        exec_req;
  logic [7:0]  exec_cmd;
  logic [31:0] exec_din;
  logic        exec_done = 1'b0;
  logic [31:0] exec_dout = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int n_req = 0;

  int          stub_lat = 0;
  logic [7:0]  stub_cmd = '0;
  logic [31:0] stub_din = '0;

  logic [9:0] exp_q[$];
  logic [9:0] got_q[$];
  string      tag_q[$];
  event       got_ev;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbl_frame_if dut_i (
    .clk       (clk),
    .rst       (rst),
    .tdi       (tdi),
    .tdo       (tdo),
    .exec_req  (exec_req),
    .exec_cmd  (exec_cmd),
    .exec_din  (exec_din),
    .exec_done (exec_done),
    .exec_dout (exec_dout)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R3 command table as seen by the host
  function automatic void tb_lookup(input logic [7:0] c, output bit known, output int nin, output int nout);
    known = 1'b1;
    case (c)
      8'h01: begin nin = 0; nout = 2; end
      8'h22: begin nin = 4; nout = 0; end
      8'h33: begin nin = 1; nout = 0; end
      8'h44: begin nin = 4; nout = 2; end
      8'h55: begin nin = 2; nout = 4; end
      default: begin known = 1'b0; nin = 0; nout = 0; end
    endcase
  endfunction

  function automatic logic [31:0] model_dout(input logic [7:0] c, input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = c ^ d[7:0] ^ (8'hA0 + 8'(i * 17));
    return r;
  endfunction

  // Scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
        logic [9:0] g;
        logic [9:0] e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g === e, t, 64'(g), 64'(e));
      end
    end
  end

  // Stub executor with programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (exec_req && !rst) begin
        n_req++;
        check(exec_cmd === stub_cmd, "R5 request command byte", 64'(exec_cmd), 64'(stub_cmd));
        check(exec_din === stub_din, "R5 request data-in bytes", 64'(exec_din), 64'(stub_din));
        repeat (stub_lat) @(negedge clk);
        exec_dout = model_dout(stub_cmd, stub_din);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
      end
    end
  end

  task automatic xfer(input logic [7:0] b, input logic [1:0] st, output logic [9:0] got);
    logic [9:0] f;
    f = {b, st};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      #1;
      tdi    = f[k];
      got[k] = tdo;
    end
  endtask

  task automatic push(input logic [9:0] g, input logic [9:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    got_q.push_back(g);
    -> got_ev;
  endtask

  task automatic xfer_exp(input logic [7:0] b, input logic [1:0] st, input logic [9:0] e, input string t);
    logic [9:0] g;
    xfer(b, st, g);
    push(g, e, t);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    tdi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic [31:0] din, input int lat, input logic [1:0] st);
    bit          known;
    int          nin;
    int          nout;
    int          busy;
    int          req_before;
    bit          fin;
    logic [9:0]  g;
    logic [31:0] dout;
    tb_lookup(cmd, known, nin, nout);
    for (int i = nin; i < 4; i++) din[8*i +: 8] = 8'h00;
    stub_cmd = cmd;
    stub_din = din;
    stub_lat = lat;
    dout = model_dout(cmd, din);
    req_before = n_req;
    xfer_exp(cmd, st, 10'h000, "R1 R2 R4 command frame");
    for (int i = 0; i < nin; i++) xfer_exp(din[8*i +: 8], st, 10'h000, "R3 R4 data-in frame");
    xfer_exp(8'h00, st, 10'h000, "R4 NOP frame");
    busy = 0;
    fin  = 1'b0;
    while (!fin && busy < 200) begin
      xfer(8'h00, st, g);
      if (g[1:0] == 2'b10) begin
        push(g, {8'h00, 2'b10}, "R6 busy poll frame");
        busy++;
      end else begin
        fin = 1'b1;
        if (!known)        push(g, {8'h3E, 2'b11}, "R9 unknown command return");
        else if (nout > 0) push(g, {dout[7:0], 2'b11}, "R7 first valid data-out");
        else               push(g, {8'h3E, 2'b11}, "R8 return byte");
      end
    end
    for (int i = 1; i <= nout; i++) begin
      if (i < nout) xfer_exp(8'h00, st, {dout[8*i +: 8], 2'b11}, "R7 data-out byte");
      else          xfer_exp(8'h00, st, {8'h3E, 2'b11}, "R8 return byte");
    end
    if (known) begin
      check(busy >= 1, "R6 busy frames before data", 64'(busy), 64'(1));
      check(n_req == req_before + 1, "R5 one request per command", 64'(n_req), 64'(req_before + 1));
    end else begin
      check(busy == 0, "R9 no busy frames", 64'(busy), 64'(0));
      check(n_req == req_before, "R9 no request", 64'(n_req), 64'(req_before));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [9:0] g;
    do_reset();
    check(exec_req === 1'b0, "R10 request low after reset", 64'(exec_req), 64'(0));
    check(tdo === 1'b0, "R10 tdo low after reset", 64'(tdo), 64'(0));

    run_cmd(8'h01, 32'h0, 3, 2'b00);
    run_cmd(8'h22, 32'hDEADBEEF, 37, 2'b00);
    run_cmd(8'h44, 32'h12345678, 0, 2'b11);   // R2 status bits set by host
    run_cmd(8'h55, 32'h0000C3A5, 12, 2'b01);  // R2
    run_cmd(8'h33, 32'h0000007E, 5, 2'b10);   // R2
    run_cmd(8'h7F, 32'h0, 0, 2'b00);          // R9
    run_cmd(8'h00, 32'h0, 0, 2'b00);          // R9
    run_cmd(8'h55, 32'h00009911, 25, 2'b00);

    // R10: reset in the middle of a command's data-in frames
    xfer_exp(8'h44, 2'b00, 10'h000, "R4 command frame before reset");
    xfer(8'hAA, 2'b00, g);
    xfer(8'hBB, 2'b00, g);
    do_reset();
    check(exec_req === 1'b0, "R10 no request after mid-command reset", 64'(exec_req), 64'(0));
    check(exec_din === 32'h0, "R10 data-in cleared by reset", 64'(exec_din), 64'(0));
    run_cmd(8'h01, 32'h0, 7, 2'b00);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", 64'(exp_q.size()), 64'(0));
    summary();
    $finish;
  end

endmodule